// File: doc/BRIEF.md
# Power-On and Watchdog Reset Sequencer

This block drives the reset line of a small microcontroller core. It has two reset sources: a digital power-good input and an internal watchdog. When power-good rises, the core is held in a semi-suspend phase of fixed length. The first part of that phase cannot be cut short. The longer second part ends early if an upstream USB bus reset arrives. When that happens, the block leaves a bus-reset event pending for the interrupt logic.

Once the core runs, the watchdog counts timebase ticks. A register-bus write to the restart address clears the watchdog, whatever the data. If software does not service it in time, the watchdog holds the core in reset for a fixed number of ticks and then releases it. Two flags record the cause of the last reset. All durations are counted in pulses of a 1 kHz tick input, so each duration is a tick-count parameter.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwrGood` is low, `cpuReset` is 1, `porFlag` is 1, `wdtFlag` is 0 and `busResetPending` is 0.
- R2: During the first LOCK_TICKS (default 1) ticks after `pwrGood` rises, `usbBusReset` has no effect: `cpuReset` stays 1 and `busResetPending` stays 0.
- R3: Without a bus reset, `cpuReset` falls on the clock edge of tick number LOCK_TICKS+WAIT_TICKS (default 96) after `pwrGood` rises. It stays 1 through tick 95.
- R4: A `usbBusReset` sampled high during the abortable phase (after the lock ticks) releases `cpuReset` on that same clock edge and sets `busResetPending` to 1.
- R5: A cycle with `busWrEn` high and `busAddr` equal to 0x26 restarts the watchdog count. A write to any other address leaves the count running.
- R6: While the core runs, the watchdog fires on tick number WDT_TICKS (default 8) after the later of release and the last restart. `cpuReset` rises on that tick's clock edge. Seven ticks do not fire it.
- R7: A watchdog reset holds `cpuReset` at 1 for WDR_TICKS (default 2) ticks. `cpuReset` falls on the edge of the second tick.
- R8: A watchdog reset sets `wdtFlag` to 1, clears `porFlag` to 0 and clears `busResetPending` to 0. A later power-on reset sets `porFlag` to 1 and clears `wdtFlag` to 0.
- R9: The watchdog does not count while `cpuReset` is 1, so a rollover during any reset hold is ignored. After each release, the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwrGood | input | 1 | Digital power-good; low forces power-on reset |
| tick | input | 1 | One-cycle pulse of the 1 kHz timebase |
| usbBusReset | input | 1 | Upstream bus reset detected |
| busWrEn | input | 1 | Register-bus write strobe |
| busAddr | input | ADDR_W | Register-bus write address |
| cpuReset | output | 1 | Synchronous active-high core reset |
| porFlag | output | 1 | Last reset came from power-on |
| wdtFlag | output | 1 | Last reset came from the watchdog |
| busResetPending | output | 1 | Bus reset aborted semi-suspend, event pending |

## Verification
A sequencer state that is off by one phase, or a phase counter off by one tick, shows up as a `cpuReset` edge one tick early or late. The bench catches this within one tick of the expected release. It probes one tick before each edge and on the edge itself. A watchdog count that is not cleared on a restart or on release shows up as a spurious reset within the seven ticks in which the core should stay running. A wrong update of the cause flags is visible on `porFlag`, `wdtFlag` and `busResetPending` on the edge that starts the reset.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    ST_LOCK   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_WDHOLD = 2'd2,
    ST_RUN    = 2'd3
  } seqState_t;

  typedef struct packed {
    logic      phaseClr;
    logic      wdtRun;
    seqState_t phase;
  } ctlStrobe_t;
endpackage

// File: rtl/rst_seq_dp.sv
module rst_seq_dp
  import rst_seq_pkg::*;
#(
  parameter int LOCK_TICKS = 1,
  parameter int WAIT_TICKS = 95,
  parameter int WDR_TICKS  = 2,
  parameter int WDT_TICKS  = 8,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 8'h26
) (
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              tick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  ctlStrobe_t        strobe,
  output logic              phaseDone,
  output logic              wdtExpire
);
  localparam int MAX_A  = (LOCK_TICKS > WAIT_TICKS) ? LOCK_TICKS : WAIT_TICKS;
  localparam int MAX_PH = (MAX_A > WDR_TICKS) ? MAX_A : WDR_TICKS;
  localparam int PH_W   = $clog2(MAX_PH + 1);
  localparam int WD_W   = $clog2(WDT_TICKS + 1);

  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLimit;
  logic [WD_W-1:0] wdtCnt;
  logic            kick;
  logic            phaseActive;

  assign kick        = busWrEn && (busAddr == KICK_ADDR);
  assign phaseActive = (strobe.phase != ST_RUN);

  always_comb begin
    case (strobe.phase)
      ST_LOCK:   phaseLimit = PH_W'(LOCK_TICKS - 1);
      ST_WAIT:   phaseLimit = PH_W'(WAIT_TICKS - 1);
      ST_WDHOLD: phaseLimit = PH_W'(WDR_TICKS - 1);
      default:   phaseLimit = '0;
    endcase
  end

  assign phaseDone = tick && phaseActive && (phaseCnt == phaseLimit);
  assign wdtExpire = strobe.wdtRun && tick && !kick && (wdtCnt == WD_W'(WDT_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!pwrGood || strobe.phaseClr || !phaseActive) begin
      phaseCnt <= '0;
    end else if (tick && (phaseCnt != phaseLimit)) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!pwrGood || !strobe.wdtRun || kick) begin
      wdtCnt <= '0;
    end else if (tick) begin
      if (wdtCnt == WD_W'(WDT_TICKS - 1)) wdtCnt <= '0;
      else wdtCnt <= wdtCnt + 1'b1;
    end
  end

  // R6: the watchdog count never passes its rollover limit
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!pwrGood)
    wdtCnt < WD_W'(WDT_TICKS));

  // R5: a restart write leaves the count at zero on the next cycle
  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!pwrGood)
    kick |=> (wdtCnt == '0));

  // R9: the count sits at zero for as long as the core is held
  a_r9_idle_in_hold: assert property (@(posedge clk) disable iff (!pwrGood)
    (!strobe.wdtRun && $past(!strobe.wdtRun)) |-> (wdtCnt == '0));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       pwrGood,
  input  logic       usbBusReset,
  input  logic       phaseDone,
  input  logic       wdtExpire,
  output ctlStrobe_t strobe,
  output logic       cpuReset,
  output logic       porFlag,
  output logic       wdtFlag,
  output logic       busResetPending
);
  seqState_t state;
  seqState_t nextState;
  logic      abortHit;
  logic      wdtHit;

  assign abortHit = (state == ST_WAIT) && usbBusReset;
  assign wdtHit   = (state == ST_RUN) && wdtExpire;

  always_comb begin
    nextState = state;
    case (state)
      ST_LOCK:   if (phaseDone) nextState = ST_WAIT;
      ST_WAIT:   if (usbBusReset || phaseDone) nextState = ST_RUN;
      ST_WDHOLD: if (phaseDone) nextState = ST_RUN;
      default:   if (wdtExpire) nextState = ST_WDHOLD;
    endcase
  end

  assign strobe.phaseClr = (nextState != state);
  assign strobe.wdtRun   = (state == ST_RUN);
  assign strobe.phase    = state;
  assign cpuReset        = (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (!pwrGood) begin
      state           <= ST_LOCK;
      porFlag         <= 1'b1;
      wdtFlag         <= 1'b0;
      busResetPending <= 1'b0;
    end else begin
      state <= nextState;
      if (abortHit) busResetPending <= 1'b1;
      if (wdtHit) begin
        wdtFlag         <= 1'b1;
        porFlag         <= 1'b0;
        busResetPending <= 1'b0;
      end
    end
  end

  // R1: power-good low forces the power-on reset state
  a_r1_por_state: assert property (@(posedge clk)
    !pwrGood |=> (cpuReset && porFlag && !wdtFlag && !busResetPending));

  // R2: the core is never released from the lock phase directly
  a_r2_lock_holds: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_LOCK) |=> cpuReset);

  // R4: a bus reset in the abortable phase releases at once and flags pending
  a_r4_abort: assert property (@(posedge clk) disable iff (!pwrGood)
    abortHit |=> (!cpuReset && busResetPending));

  // R8: a watchdog cause never coexists with a fresh power-on cause
  a_r8_cause: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(wdtFlag) |-> (!porFlag && !busResetPending));

  // R9: the datapath reports expiry only while the core runs
  a_r9_expire_running: assert property (@(posedge clk) disable iff (!pwrGood)
    wdtExpire |-> (state == ST_RUN));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int LOCK_TICKS = 1,
  parameter int WAIT_TICKS = 95,
  parameter int WDR_TICKS  = 2,
  parameter int WDT_TICKS  = 8,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 8'h26
) (
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              tick,
  input  logic              usbBusReset,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              cpuReset,
  output logic              porFlag,
  output logic              wdtFlag,
  output logic              busResetPending
);
  ctlStrobe_t strobe;
  logic       phaseDone;
  logic       wdtExpire;

  rst_seq_ctrl i_ctrl (
    .clk             (clk),
    .pwrGood         (pwrGood),
    .usbBusReset     (usbBusReset),
    .phaseDone       (phaseDone),
    .wdtExpire       (wdtExpire),
    .strobe          (strobe),
    .cpuReset        (cpuReset),
    .porFlag         (porFlag),
    .wdtFlag         (wdtFlag),
    .busResetPending (busResetPending)
  );

  rst_seq_dp #(
    .LOCK_TICKS (LOCK_TICKS),
    .WAIT_TICKS (WAIT_TICKS),
    .WDR_TICKS  (WDR_TICKS),
    .WDT_TICKS  (WDT_TICKS),
    .ADDR_W     (ADDR_W),
    .KICK_ADDR  (KICK_ADDR)
  ) i_dp (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .tick      (tick),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .strobe    (strobe),
    .phaseDone (phaseDone),
    .wdtExpire (wdtExpire)
  );
endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // each row: {ticks after restart, expected cpuReset}
  localparam logic [8:0] WD_VEC [NVEC] = '{
    {8'd7, 1'b0}, {8'd8, 1'b1}, {8'd3, 1'b0}, {8'd8, 1'b1}, {8'd1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       pwrGood = 1'b0;
  logic       tick = 1'b0;
  logic       usbBusReset = 1'b0;
  logic       busWrEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       cpuReset, porFlag, wdtFlag, busResetPending;
  int         nRun = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rst_sequencer i_rst_sequencer (
    .clk (clk), .pwrGood (pwrGood), .tick (tick), .usbBusReset (usbBusReset),
    .busWrEn (busWrEn), .busAddr (busAddr), .cpuReset (cpuReset),
    .porFlag (porFlag), .wdtFlag (wdtFlag), .busResetPending (busResetPending)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic busWrite(input logic [7:0] addr);
    @(negedge clk) begin busWrEn = 1'b1; busAddr = addr; end
    @(negedge clk) busWrEn = 1'b0;
  endtask

  task automatic busResetPulse();
    @(negedge clk) usbBusReset = 1'b1;
    @(negedge clk) usbBusReset = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cpuReset", cpuReset, 1'b1);
    check("R1 porFlag", porFlag, 1'b1);
    check("R1 wdtFlag", wdtFlag, 1'b0);
    check("R1 pending", busResetPending, 1'b0);

    @(negedge clk) pwrGood = 1'b1;
    busResetPulse();
    check("R2 cpuReset held", cpuReset, 1'b1);
    check("R2 pending clear", busResetPending, 1'b0);
    tickN(1);
    check("R2 after lock", cpuReset, 1'b1);
    tickN(94);
    check("R3 tick 95", cpuReset, 1'b1);
    tickN(1);
    check("R3 tick 96", cpuReset, 1'b0);
    check("R3 porFlag", porFlag, 1'b1);

    tickN(7);
    check("R9 fresh count after por", cpuReset, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      busWrite(8'h26);
      tickN(int'(WD_VEC[v][8:1]));
      check($sformatf("R6 row %0d", v), cpuReset, WD_VEC[v][0]);
      if (WD_VEC[v][0]) begin
        check("R8 wdtFlag", wdtFlag, 1'b1);
        check("R8 porFlag", porFlag, 1'b0);
        tickN(1);
        check("R7 hold tick 1", cpuReset, 1'b1);
        tickN(1);
        check("R7 release tick 2", cpuReset, 1'b0);
      end else begin
        check("R5 restart kept running", cpuReset, 1'b0);
      end
    end

    busWrite(8'h26);
    tickN(7);
    busWrite(8'h25);
    tickN(1);
    check("R5 other address ignored", cpuReset, 1'b1);
    tickN(2);
    check("R7 release", cpuReset, 1'b0);
    tickN(7);
    check("R9 fresh count after wdr", cpuReset, 1'b0);

    @(negedge clk) pwrGood = 1'b0;
    @(negedge clk);
    check("R8 por sets porFlag", porFlag, 1'b1);
    check("R8 por clears wdtFlag", wdtFlag, 1'b0);
    check("R1 cpuReset again", cpuReset, 1'b1);
    pwrGood = 1'b1;
    tickN(11);
    check("R4 before abort", cpuReset, 1'b1);
    busResetPulse();
    check("R4 released", cpuReset, 1'b0);
    check("R4 pending", busResetPending, 1'b1);
    tickN(8);
    check("R8 wdr reset", cpuReset, 1'b1);
    check("R8 pending cleared", busResetPending, 1'b0);
    check("R8 wdtFlag set", wdtFlag, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule